// File: doc/BRIEF.md
# Inverted-Data Serial Packet Transmitter

This block drives one shared single-wire line from a byte source. On a start strobe it frames a packet of 1 to 256 data bytes plus one trailing check byte. All timing is counted in clock cycles. A multi-pulse start sequence lets a receiver find the first bit. Each byte is serialized most-significant bit first with inverted polarity. Every byte after the first is preceded by a low gap and a short high servo pulse, which a receiver uses to trim its sampling phase.

Data bytes are pulled one at a time through a request/acknowledge fetch port, with the byte index presented alongside the request. The check byte is the XOR of all data bytes and is built up as they arrive. While idle, the line carries a lock request from the surrounding logic, so an asserted lock simply lengthens the leading high pulse of the next packet. A single-cycle done pulse marks the end of the packet.

Top module: `wire_pkt_tx`

## Requirements
- R1: After reset the line is low, `doneOut` is low and `fetchReq` is low; while idle the line follows `holdReq`.
- R2: The clock after a start strobe is accepted, the line goes high for exactly 31 cycles, then low for 16, high for 8, and then low for at least 8 before an 8-cycle high servo pulse that leads into the first byte.
- R3: Each bit holds the line for 8 cycles, bit 7 first and bit 0 last, with inverted polarity: a stored 1 is a low line and a stored 0 is a high line.
- R4: Between consecutive bytes (including before the check byte) the line is low for 22 cycles and then high for 8 cycles (servo) before the next byte's bit 7.
- R5: `lenIn` holds the byte count minus one (0 means 1 byte, 255 means 256 bytes). Exactly `lenIn`+1 data bytes are fetched, at indices 0, 1, 2 … in order, one fetch per byte.
- R6: After the last data byte the block sends one extra byte equal to the XOR of all data bytes, with the same gap, servo and bit timing.
- R7: After the check byte's bit 0 the line goes low and stays low (with `holdReq` low). `doneOut` is high for exactly one cycle, the cycle after the first idle cycle.
- R8: With `holdReq` high while idle the line is high. A packet started during the hold keeps its own 31-cycle start pulse, so the total high time is the hold time plus 31.
- R9: If a byte has not arrived when a pre-servo low phase would end, that low phase is stretched until the byte has been captured. The servo pulse and the bits that follow are unchanged.
- R10: A start strobe during a packet is ignored: the packet in flight is unchanged and no new packet follows it.
- R11: Once raised, `fetchReq` stays high with a stable `fetchIdx` until `fetchAck` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe, accepted only while idle |
| lenIn | input | 8 | Data byte count minus one, latched at start |
| holdReq | input | 1 | Lock request; drives the line high while idle |
| fetchReq | output | 1 | Request for the next data byte |
| fetchIdx | output | 8 | Index of the requested data byte |
| fetchAck | input | 1 | Requested byte is on `fetchData` this cycle |
| fetchData | input | 8 | Requested data byte |
| lineOut | output | 1 | Serial line level |
| doneOut | output | 1 | One-cycle end-of-packet pulse |

## Verification
The in-RTL assertions check, on every cycle, the properties that are local in time:
- the line never moves inside a bit cell;
- a servo pulse is entered only with a byte captured;
- the fetch request holds with a steady index until it is acknowledged;
- `doneOut` is a lone pulse that follows an idle cycle.

The whole-packet shape can only be shown by the bench's scenarios, which record the line and decode it position by position. That shape covers the exact preamble and gap lengths, bit order and polarity, the check byte value, the stretch length under a slow byte source, lock lengthening and a stray start strobe.

// File: rtl/wire_pkt_tx_pkg.sv
package wire_pkt_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_SYNC,
    PH_COARSE,
    PH_PRELO,
    PH_SERVO,
    PH_BITS,
    PH_GAP
  } phase_t;

  typedef struct packed {
    logic clear;      // new packet: latch length, reset index and check
    logic reqFetch;   // raise a byte request
    logic loadCheck;  // stage the check byte as next byte
    logic loadShift;  // move staged byte into the shifter
    logic shift;      // advance to the next bit
  } dpCtrl_t;

endpackage

// File: rtl/wire_pkt_tx_dp.sv
module wire_pkt_tx_dp
  import wire_pkt_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 256,
  localparam int LEN_W    = $clog2(MAX_BYTES),
  localparam int IDX_W    = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              fetchAck,
  input  logic [DATA_W-1:0] fetchData,
  output logic              fetchReq,
  output logic [LEN_W-1:0]  fetchIdx,
  output logic              byteReady,
  output logic              allFetched,
  output logic              shIsCheck,
  output logic              txBit
);

  logic [LEN_W-1:0]  lenReg;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] chkAcc;
  logic [DATA_W-1:0] staged;
  logic              stagedIsChk;
  logic              pending;
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg      <= '0;
      idx         <= '0;
      chkAcc      <= '0;
      staged      <= '0;
      stagedIsChk <= 1'b0;
      pending     <= 1'b0;
      byteReady   <= 1'b0;
      shReg       <= '0;
      shIsCheck   <= 1'b0;
    end else begin
      if (ctl.clear) begin
        lenReg      <= lenIn;
        idx         <= '0;
        chkAcc      <= '0;
        stagedIsChk <= 1'b0;
        byteReady   <= 1'b0;
      end
      if (ctl.reqFetch) begin
        pending <= 1'b1;
      end else if (pending && fetchAck) begin
        pending   <= 1'b0;
        staged    <= fetchData;
        chkAcc    <= chkAcc ^ fetchData;
        idx       <= idx + 1'b1;
        byteReady <= 1'b1;
      end
      if (ctl.loadCheck) begin
        staged      <= chkAcc;
        stagedIsChk <= 1'b1;
        byteReady   <= 1'b1;
      end
      if (ctl.loadShift) begin
        shReg     <= staged;
        shIsCheck <= stagedIsChk;
        byteReady <= 1'b0;
      end else if (ctl.shift) begin
        shReg <= {shReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign fetchReq   = pending;
  assign fetchIdx   = idx[LEN_W-1:0];
  assign allFetched = (idx == ({1'b0, lenReg} + 1'b1));
  assign txBit      = ~shReg[DATA_W-1];

  // R11: request held, index steady, until acknowledged
  assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck) |=> (fetchReq && $stable(fetchIdx)));

  // R6: check byte is staged only with no data fetch outstanding
  assert_check_no_fetch_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCheck |-> !pending);

endmodule

// File: rtl/wire_pkt_tx_ctrl.sv
module wire_pkt_tx_ctrl
  import wire_pkt_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BIT_CLKS   = 8,
  parameter int START_CLKS = 31,
  parameter int SYNC_CLKS  = 16,
  parameter int MARK_CLKS  = 8,
  parameter int GAP_CLKS   = 22,
  localparam int CNT_W     = $clog2(START_CLKS + SYNC_CLKS + GAP_CLKS + MARK_CLKS + BIT_CLKS),
  localparam int BITN_W    = $clog2(DATA_W)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    holdReq,
  input  logic    byteReady,
  input  logic    allFetched,
  input  logic    shIsCheck,
  input  logic    txBit,
  output dpCtrl_t ctl,
  output logic    lineOut,
  output logic    doneOut
);

  phase_t            ph, nPh;
  logic [CNT_W-1:0]  cnt, nCnt;
  logic [BITN_W-1:0] bitLeft, nBitLeft;
  logic              finish, finFlag;

  always_comb begin
    ctl      = '0;
    nPh      = ph;
    nCnt     = (cnt != '0) ? cnt - 1'b1 : cnt;
    nBitLeft = bitLeft;
    finish   = 1'b0;
    unique case (ph)
      PH_IDLE: if (startIn) begin
        nPh          = PH_START;
        nCnt         = CNT_W'(START_CLKS - 1);
        ctl.clear    = 1'b1;
        ctl.reqFetch = 1'b1;
      end
      PH_START: if (cnt == '0) begin
        nPh  = PH_SYNC;
        nCnt = CNT_W'(SYNC_CLKS - 1);
      end
      PH_SYNC: if (cnt == '0) begin
        nPh  = PH_COARSE;
        nCnt = CNT_W'(MARK_CLKS - 1);
      end
      PH_COARSE: if (cnt == '0) begin
        nPh  = PH_PRELO;
        nCnt = CNT_W'(MARK_CLKS - 1);
      end
      PH_PRELO, PH_GAP: if (cnt == '0 && byteReady) begin
        nPh  = PH_SERVO;
        nCnt = CNT_W'(MARK_CLKS - 1);
      end
      PH_SERVO: if (cnt == '0) begin
        nPh           = PH_BITS;
        nCnt          = CNT_W'(BIT_CLKS - 1);
        nBitLeft      = BITN_W'(DATA_W - 1);
        ctl.loadShift = 1'b1;
      end
      PH_BITS: if (cnt == '0) begin
        if (bitLeft != '0) begin
          ctl.shift = 1'b1;
          nCnt      = CNT_W'(BIT_CLKS - 1);
          nBitLeft  = bitLeft - 1'b1;
        end else if (shIsCheck) begin
          nPh    = PH_IDLE;
          finish = 1'b1;
        end else begin
          nPh  = PH_GAP;
          nCnt = CNT_W'(GAP_CLKS - 1);
          if (allFetched) ctl.loadCheck = 1'b1;
          else            ctl.reqFetch  = 1'b1;
        end
      end
      default: nPh = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (ph)
      PH_IDLE:                       lineOut = holdReq;
      PH_START, PH_COARSE, PH_SERVO: lineOut = 1'b1;
      PH_BITS:                       lineOut = txBit;
      default:                       lineOut = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      bitLeft <= '0;
      finFlag <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      ph      <= nPh;
      cnt     <= nCnt;
      bitLeft <= nBitLeft;
      finFlag <= finish;
      doneOut <= finFlag;
    end
  end

  // R7: done is a lone pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R7: done follows a cycle spent idle
  assert_done_after_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> ($past(ph) == PH_IDLE));

  // R9: servo is only entered once the next byte has been captured
  assert_servo_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_SERVO && $past(ph) != PH_SERVO) |-> $past(byteReady));

  // R3: line level is steady inside a bit cell
  assert_bit_cell_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_BITS && $past(ph) == PH_BITS && $past(cnt) != '0) |-> $stable(lineOut));

endmodule

// File: rtl/wire_pkt_tx.sv
module wire_pkt_tx
  import wire_pkt_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MAX_BYTES  = 256,
  parameter int BIT_CLKS   = 8,
  parameter int START_CLKS = 31,
  parameter int SYNC_CLKS  = 16,
  parameter int MARK_CLKS  = 8,
  parameter int GAP_CLKS   = 22,
  localparam int LEN_W     = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              holdReq,
  output logic              fetchReq,
  output logic [LEN_W-1:0]  fetchIdx,
  input  logic              fetchAck,
  input  logic [DATA_W-1:0] fetchData,
  output logic              lineOut,
  output logic              doneOut
);

  dpCtrl_t ctl;
  logic    byteReady, allFetched, shIsCheck, txBit;

  wire_pkt_tx_ctrl #(
    .DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS), .START_CLKS(START_CLKS),
    .SYNC_CLKS(SYNC_CLKS), .MARK_CLKS(MARK_CLKS), .GAP_CLKS(GAP_CLKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .holdReq(holdReq),
    .byteReady(byteReady), .allFetched(allFetched), .shIsCheck(shIsCheck),
    .txBit(txBit), .ctl(ctl), .lineOut(lineOut), .doneOut(doneOut)
  );

  wire_pkt_tx_dp #(
    .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lenIn(lenIn),
    .fetchAck(fetchAck), .fetchData(fetchData),
    .fetchReq(fetchReq), .fetchIdx(fetchIdx), .byteReady(byteReady),
    .allFetched(allFetched), .shIsCheck(shIsCheck), .txBit(txBit)
  );

endmodule

// File: tb/tb_wire_pkt_tx.sv
`timescale 1ns/1ps
module tb_wire_pkt_tx;

  localparam int MAXREC = 32768;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [7:0] lenIn = '0;
  logic       holdReq = 1'b0;
  logic       fetchReq;
  logic [7:0] fetchIdx;
  logic       fetchAck = 1'b0;
  logic [7:0] fetchData = '0;
  logic       lineOut;
  logic       doneOut;

  int tests = 0;
  int fails = 0;

  logic [7:0] mem [256];
  bit         rec [MAXREC];
  bit         dn  [MAXREC];
  int         ackDelay = 0;
  int         waitCnt = 0;
  int         respIdx = 0;
  int         idxErr = 0;

  always #2 clk = ~clk;

  wire_pkt_tx dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lenIn(lenIn), .holdReq(holdReq),
    .fetchReq(fetchReq), .fetchIdx(fetchIdx), .fetchAck(fetchAck),
    .fetchData(fetchData), .lineOut(lineOut), .doneOut(doneOut)
  );

  // byte source with programmable response delay
  initial begin
    forever begin
      @(negedge clk);
      if (fetchAck) begin
        fetchAck = 1'b0;
      end else if (fetchReq) begin
        if (waitCnt >= ackDelay) begin
          if (int'(fetchIdx) != respIdx) idxErr++;
          fetchData = mem[fetchIdx];
          fetchAck  = 1'b1;
          respIdx++;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int runOf(int p, bit v);
    int n = 0;
    while (p + n < MAXREC && rec[p + n] == v) n++;
    return n;
  endfunction

  // start a packet, record the line to the done pulse, then decode it by position
  task automatic runPacket(int len, int d, bit poke, string name);
    int doneAt = -1;
    int p = 0;
    int n;
    logic [7:0] chk = '0;
    ackDelay = d; respIdx = 0; idxErr = 0; waitCnt = 0;
    for (int k = 0; k <= len; k++) chk ^= mem[k];
    @(negedge clk);
    lenIn = 8'(len); startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0; holdReq = 1'b0;
    for (int i = 0; i < MAXREC; i++) begin
      rec[i] = lineOut; dn[i] = doneOut;
      startIn = (poke && i == 150);
      if (doneOut && doneAt < 0) doneAt = i;
      if (doneAt >= 0 && i >= doneAt + 2) break;
      @(negedge clk);
    end
    startIn = 1'b0;
    // preamble, R2
    n = runOf(p, 1'b1); check(n == 31, {name, " R2 start pulse"}, n, 31); p += n;
    n = runOf(p, 1'b0); check(n == 16, {name, " R2 sync low"}, n, 16); p += n;
    n = runOf(p, 1'b1); check(n == 8, {name, " R2 coarse high"}, n, 8); p += n;
    n = runOf(p, 1'b0); check(n == 8, {name, " R2 pre-servo low"}, n, 8); p += n;
    for (int k = 0; k <= len + 1; k++) begin
      int   srv = 0;
      bit   cellOk = 1;
      logic [7:0] got = '0;
      logic [7:0] exp = (k <= len) ? mem[k] : chk;
      if (k > 0) begin
        int expGap = (k <= len && d + 2 > 22) ? d + 2 : 22;
        n = runOf(p, 1'b0);
        check(n == expGap, {name, " R4/R9 gap low"}, n, expGap);
        p += n;
      end
      for (int c = 0; c < 8; c++) srv += rec[p + c];
      check(srv == 8, {name, " R4 servo high"}, srv, 8);
      p += 8;
      for (int b = 7; b >= 0; b--) begin
        for (int c = 1; c < 8; c++) if (rec[p + c] != rec[p]) cellOk = 0;
        got[b] = ~rec[p];
        p += 8;
      end
      check(cellOk, {name, " R3 bit cell width"}, int'(cellOk), 1);
      if (k <= len) check(got == exp, {name, " R3 data byte"}, got, exp);
      else          check(got == exp, {name, " R6 check byte"}, got, exp);
    end
    check(rec[p] == 0 && dn[p] == 0 && dn[p + 1] == 1 && dn[p + 2] == 0,
          {name, " R7 idle and done timing"}, doneAt, p + 1);
    check(idxErr == 0 && respIdx == len + 1, {name, " R5/R11 fetch order and count"},
          respIdx - idxErr, len + 1);
  endtask

  task automatic expectIdleLow(int cyc, string tag);
    int highs = 0;
    int dones = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      highs += lineOut; dones += doneOut;
    end
    check(highs == 0 && dones == 0, tag, highs + dones, 0);
  endtask

  task automatic testReset();
    check(lineOut == 0 && doneOut == 0 && fetchReq == 0, "R1 reset state",
          {lineOut, doneOut, fetchReq}, 0);
  endtask

  task automatic testSingle();
    mem[0] = 8'hA5;
    runPacket(0, 0, 0, "single");
    expectIdleLow(20, "R7 idle after single");
  endtask

  task automatic testFew();
    mem[0] = 8'h3C; mem[1] = 8'h81; mem[2] = 8'h7E; mem[3] = 8'h12;
    runPacket(3, 0, 0, "four");
  endtask

  task automatic testPolarity();
    mem[0] = 8'h00; mem[1] = 8'hFF; mem[2] = 8'h01; mem[3] = 8'h80;
    runPacket(3, 0, 0, "polarity R3");
  endtask

  task automatic testMax();
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + 3);
    runPacket(255, 0, 0, "max R5");
  endtask

  task automatic testStretch();
    mem[0] = 8'hC3; mem[1] = 8'h5A; mem[2] = 8'hE7;
    runPacket(2, 40, 0, "slow R9");
  endtask

  task automatic testHold();
    int highs = 0;
    holdReq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      highs += lineOut;
    end
    check(highs == 10, "R8 hold keeps idle line high", highs, 10);
    mem[0] = 8'h96; mem[1] = 8'h4B;
    runPacket(1, 0, 0, "hold R8");
    expectIdleLow(10, "R1 idle follows hold low");
  endtask

  task automatic testBusyStart();
    mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'h44; mem[3] = 8'h88; mem[4] = 8'hF0;
    runPacket(4, 0, 1, "busy R10");
    expectIdleLow(300, "R10 no second packet");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testFew();
    testPolarity();
    testStretch();
    testHold();
    testBusyStart();
    testMax();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule